// File: doc/BRIEF.md
# E1 Elastic Store with Controlled Frame Slip

This block is a two-frame bit buffer that carries a 2.048 Mbps E1 stream from a line-side write strobe to a backplane-side read strobe. The two strobes have independent frequency and phase. Both sides run on one system clock and move one bit per single-cycle strobe. The read side may be bursty, with strobes on consecutive cycles and gaps between them. The buffer absorbs wander between the two sides. When the read side drifts too close to the write side, or too far from it, the block slips: a whole 256-bit frame is repeated or dropped, so frame alignment survives.

The write side marks the first bit of every incoming frame with a frame sync. It may also tag that frame as the start of a channel-signalling multiframe or a CRC multiframe. The read side drives a frame sync with the first bit of every output frame. When enabled, it also drives a multiframe sync on frames that carry the selected tag.

A rate-select input switches the backplane side to a 1.544 Mbps layout. Each output frame is then 193 bits long: a leading framing bit that is always 1, followed by 24 timeslots. Every fourth timeslot of the line frame is left out. A re-centre pulse restarts the read side at a known position relative to the writer.

Top module: `e1_elastic_store`

## Requirements
- R1: While reset is applied, and after it is released, rd_bit, rd_fsync, rd_msync, slip_pulse, slip_under and slip_over are all 0.
- R2: In 2.048 mode (t1_mode=0), each output frame is the 256 bits of one written frame, in write order. The output frame sync is high with its first bit only.
- R3: The outputs rd_bit, rd_fsync and rd_msync change only in the cycle after a cycle with rd_en high. Without a read strobe they hold their values.
- R4: At an output frame boundary, if fewer than GUARD bits have been written since the start of the frame about to be read, the frame read last is output again. slip_pulse is high for one cycle and slip_under is set.
- R5: At an output frame boundary, if DEPTH-GUARD or more bits have been written since the start of the frame about to be read, that frame is skipped and the next one is read. slip_pulse is high for one cycle and slip_over is set.
- R6: slip_under and slip_over stay set until a clr_status pulse clears them. A slip on the same cycle as the clear takes priority. slip_pulse never lasts longer than one cycle.
- R7: A recenter pulse restarts the read side at bit 0 of the frame opposite the one the writer occupies.
- R8: In 1.544 mode (t1_mode=1), each output frame has 193 bits. Bit 0 is a framing bit driven to 1, and the frame sync is high with it. Output bits 1..192 are line timeslots 1,2,3,5,6,7,...,29,30,31, taken in order, 8 bits each. Timeslots whose index is a multiple of 4 are omitted.
- R9: With msync_en=1, rd_msync is high with the first bit of each output frame whose first written bit carried the selected tag. The tag is wr_cas_mf when msync_crc=0 and wr_crc_mf when msync_crc=1. With msync_en=0, rd_msync stays 0.
- R10: A write with wr_fsync high at a write position other than 0 is stored at bit 0 of the next frame. The bits after it follow from there.
- R11: While the depth stays inside the guard band, no slip occurs, and both slip flags remain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Line-side bit strobe |
| wr_bit | input | 1 | Line-side data bit |
| wr_fsync | input | 1 | Marks the first bit of a line frame |
| wr_cas_mf | input | 1 | Tags the frame as a signalling multiframe start (with the first bit) |
| wr_crc_mf | input | 1 | Tags the frame as a CRC multiframe start (with the first bit) |
| rd_en | input | 1 | Backplane-side bit strobe |
| t1_mode | input | 1 | 1: 193-bit backplane frames, 0: 256-bit frames |
| msync_en | input | 1 | Enables the multiframe sync output |
| msync_crc | input | 1 | Selects the CRC tag (1) or the signalling tag (0) |
| recenter | input | 1 | Restarts the read side opposite the writer |
| clr_status | input | 1 | Clears the sticky slip flags |
| rd_bit | output | 1 | Backplane-side data bit |
| rd_fsync | output | 1 | High with the first bit of each output frame |
| rd_msync | output | 1 | High with the first bit of a tagged output frame |
| slip_pulse | output | 1 | One-cycle pulse on each slip |
| slip_under | output | 1 | Sticky: a frame was repeated |
| slip_over | output | 1 | Sticky: a frame was dropped |

## Verification
The hard situation to reach is the slip itself. It happens only when the read/write separation, sampled at an output frame boundary, has drifted into the guard band. That takes several frames of sustained rate mismatch, and the drift per frame must stay smaller than the guard, or the reader overruns the writer inside a frame. The stimulus first pre-fills one frame and re-centres, so the start depth is exactly half the buffer. It then runs the reader at 8/7 of the writer's rate, and later the writer at 8/7 of the reader's rate. The separation moves by a few dozen bits per frame until exactly one repeat or one drop occurs. The scoreboard then expects the previous frame index again, or discards one queued index.

// File: rtl/es_pkg.sv
package es_pkg;

  // Slip decision taken at a read-side frame boundary.
  typedef struct packed {
    logic under;  // frame repeated
    logic over;   // frame skipped
  } slip_ev_t;

  // Backplane timeslot (rate-converted) to line timeslot, skipping
  // every drop-th line slot starting with slot 0.
  function automatic int unsigned bp_to_line_slot(int unsigned ts, int unsigned drop);
    return drop * (ts / (drop - 1)) + (ts % (drop - 1)) + 1;
  endfunction

endpackage

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_fsync,
  input  logic          wr_cas_mf,
  input  logic          wr_crc_mf,
  output logic [PW:0]   waddr,
  output logic [PW:0]   wptr,
  output logic [1:0]    tag_cas,
  output logic [1:0]    tag_crc
);

  localparam int AW = PW + 1;

  logic [AW-1:0] wptr_q, wptr_d;
  logic [1:0]    cas_q, cas_d, crc_q, crc_d;
  logic          realign;

  always_comb begin
    realign = wr_fsync && (wptr_q[PW-1:0] != '0);
    waddr   = realign ? {~wptr_q[AW-1], {PW{1'b0}}} : wptr_q;
    wptr_d  = wr_en ? waddr + AW'(1) : wptr_q;
  end

  // One tag register pair per frame slot, written with the frame's first bit.
  for (genvar s = 0; s < 2; s++) begin : g_tag
    always_comb begin
      cas_d[s] = cas_q[s];
      crc_d[s] = crc_q[s];
      if (wr_en && (waddr[PW-1:0] == '0) && (waddr[AW-1] == 1'(s))) begin
        cas_d[s] = wr_cas_mf;
        crc_d[s] = wr_crc_mf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cas_q  <= '0;
      crc_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      cas_q  <= cas_d;
      crc_q  <= crc_d;
    end
  end

  assign wptr    = wptr_q;
  assign tag_cas = cas_q;
  assign tag_crc = crc_q;

  // R10: a frame sync always lands the written bit at position 0
  a_r10_fsync_aligns: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fsync) |=> (wptr_q[PW-1:0] == PW'(1)));

endmodule

// File: rtl/es_bit_ram.sv
module es_bit_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl import es_pkg::*; #(
  parameter int TS_BITS    = 8,
  parameter int N_TS       = 32,
  parameter int DROP_EVERY = 4,
  parameter int GUARD      = 64
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rd_en,
  input  logic                                 t1_mode,
  input  logic                                 recenter,
  input  logic [$clog2(TS_BITS*N_TS):0]        wptr,
  output logic [$clog2(TS_BITS*N_TS):0]        raddr,
  output logic                                 fbit,
  output logic                                 frame_start,
  output slip_ev_t                             slip,
  output logic                                 cur_slot
);

  localparam int FRAME_BITS = TS_BITS * N_TS;
  localparam int PW         = $clog2(FRAME_BITS);
  localparam int AW         = PW + 1;
  localparam int DEPTH      = 2 * FRAME_BITS;
  localparam int TW         = $clog2(TS_BITS);
  localparam int SW         = $clog2(N_TS);
  localparam int BP_LEN     = 1 + (N_TS - N_TS / DROP_EVERY) * TS_BITS;

  logic [PW-1:0] rcnt_q, rcnt_d;
  logic          rframe_q, rframe_d;
  logic [AW-1:0] depth;
  logic          at_start, last, strobe;
  logic [PW-1:0] k;
  logic [SW-1:0] bp_ts, line_ts;
  logic [PW-1:0] pos;
  slip_ev_t      raw;

  always_comb begin
    at_start  = (rcnt_q == '0);
    strobe    = rd_en && !recenter;
    depth     = wptr - {rframe_q, {PW{1'b0}}};
    raw.under = at_start && (depth < AW'(GUARD));
    raw.over  = at_start && (depth >= AW'(DEPTH - GUARD));
    cur_slot  = (raw.under || raw.over) ? ~rframe_q : rframe_q;

    k       = rcnt_q - PW'(1);
    bp_ts   = k[PW-1:TW];
    line_ts = SW'(bp_to_line_slot(32'(bp_ts), DROP_EVERY));
    if (t1_mode) pos = at_start ? '0 : {line_ts, k[TW-1:0]};
    else         pos = rcnt_q;
    raddr = {cur_slot, pos};

    fbit        = t1_mode && at_start;
    frame_start = strobe && at_start;
    slip.under  = strobe && raw.under;
    slip.over   = strobe && raw.over;
    last        = t1_mode ? (rcnt_q >= PW'(BP_LEN - 1)) : (rcnt_q == {PW{1'b1}});
  end

  always_comb begin
    rcnt_d   = rcnt_q;
    rframe_d = rframe_q;
    if (recenter) begin
      rcnt_d   = '0;
      rframe_d = ~wptr[AW-1];
    end else if (rd_en) begin
      if (last) begin
        rcnt_d   = '0;
        rframe_d = ~cur_slot;
      end else begin
        rcnt_d   = rcnt_q + PW'(1);
        rframe_d = cur_slot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q   <= '0;
      rframe_q <= 1'b1;
    end else begin
      rcnt_q   <= rcnt_d;
      rframe_q <= rframe_d;
    end
  end

endmodule

// File: rtl/e1_elastic_store.sv
module e1_elastic_store import es_pkg::*; #(
  parameter int TS_BITS    = 8,
  parameter int N_TS       = 32,
  parameter int DROP_EVERY = 4,
  parameter int GUARD      = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic wr_fsync,
  input  logic wr_cas_mf,
  input  logic wr_crc_mf,
  input  logic rd_en,
  input  logic t1_mode,
  input  logic msync_en,
  input  logic msync_crc,
  input  logic recenter,
  input  logic clr_status,
  output logic rd_bit,
  output logic rd_fsync,
  output logic rd_msync,
  output logic slip_pulse,
  output logic slip_under,
  output logic slip_over
);

  localparam int FRAME_BITS = TS_BITS * N_TS;
  localparam int PW         = $clog2(FRAME_BITS);
  localparam int AW         = PW + 1;
  localparam int DEPTH      = 2 * FRAME_BITS;

  // Asynchronous assertion, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic [AW-1:0] waddr, wptr, raddr;
  logic [1:0]    tag_cas, tag_crc;
  logic          ram_q, fbit, frame_start, cur_slot;
  slip_ev_t      slip;

  es_wr_ctrl #(.PW(PW)) u_wr (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_fsync(wr_fsync),
    .wr_cas_mf(wr_cas_mf), .wr_crc_mf(wr_crc_mf), .waddr(waddr), .wptr(wptr),
    .tag_cas(tag_cas), .tag_crc(tag_crc)
  );

  es_bit_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata(wr_bit),
    .raddr(raddr), .rdata(ram_q)
  );

  es_rd_ctrl #(
    .TS_BITS(TS_BITS), .N_TS(N_TS), .DROP_EVERY(DROP_EVERY), .GUARD(GUARD)
  ) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .t1_mode(t1_mode),
    .recenter(recenter), .wptr(wptr), .raddr(raddr), .fbit(fbit),
    .frame_start(frame_start), .slip(slip), .cur_slot(cur_slot)
  );

  logic bit_d, fs_d, ms_d, pulse_d, under_d, over_d, tag_sel;

  always_comb begin
    tag_sel = msync_crc ? tag_crc[cur_slot] : tag_cas[cur_slot];
    bit_d   = rd_bit;
    fs_d    = rd_fsync;
    ms_d    = rd_msync;
    if (rd_en && !recenter) begin
      bit_d = fbit ? 1'b1 : ram_q;
      fs_d  = frame_start;
      ms_d  = frame_start && msync_en && tag_sel;
    end
    pulse_d = slip.under || slip.over;
    under_d = slip.under ? 1'b1 : (clr_status ? 1'b0 : slip_under);
    over_d  = slip.over  ? 1'b1 : (clr_status ? 1'b0 : slip_over);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_bit     <= 1'b0;
      rd_fsync   <= 1'b0;
      rd_msync   <= 1'b0;
      slip_pulse <= 1'b0;
      slip_under <= 1'b0;
      slip_over  <= 1'b0;
    end else begin
      rd_bit     <= bit_d;
      rd_fsync   <= fs_d;
      rd_msync   <= ms_d;
      slip_pulse <= pulse_d;
      slip_under <= under_d;
      slip_over  <= over_d;
    end
  end

  // R3: outputs hold when no read strobe was given
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> ($stable(rd_bit) && $stable(rd_fsync) && $stable(rd_msync)));
  // R4 / R5: every slip pulse comes with a direction flag
  a_r4_r5_pulse_has_dir: assert property (@(posedge clk) disable iff (!rst_sync_n)
    slip_pulse |-> (slip_under || slip_over));
  // R6: slip pulse is a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    slip_pulse |=> !slip_pulse);
  // R6: flags are sticky until cleared
  a_r6_sticky_under: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (slip_under && !clr_status) |=> slip_under);
  a_r6_sticky_over: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (slip_over && !clr_status) |=> slip_over);
  // R8: the framing bit of a 193-bit frame is one
  a_r8_fbit_one: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (t1_mode && $stable(t1_mode) && rd_fsync) |-> rd_bit);
  // R9: multiframe sync only on a frame's first bit
  a_r9_msync_on_frame: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_msync |-> rd_fsync);

endmodule

// File: tb/e1_elastic_store_test.sv
module e1_elastic_store_test;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_bit, wr_fsync, wr_cas_mf, wr_crc_mf;
  logic rd_en, t1_mode, msync_en, msync_crc, recenter, clr_status;
  logic rd_bit, rd_fsync, rd_msync, slip_pulse, slip_under, slip_over;

  always #4 clk = ~clk;

  e1_elastic_store uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .wr_fsync(wr_fsync),
    .wr_cas_mf(wr_cas_mf), .wr_crc_mf(wr_crc_mf), .rd_en(rd_en), .t1_mode(t1_mode),
    .msync_en(msync_en), .msync_crc(msync_crc), .recenter(recenter),
    .clr_status(clr_status), .rd_bit(rd_bit), .rd_fsync(rd_fsync),
    .rd_msync(rd_msync), .slip_pulse(slip_pulse), .slip_under(slip_under),
    .slip_over(slip_over)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  // phase settings read by the monitor
  logic ph_t1, ph_men, ph_crc;
  int   ph_kind;  // 0 none, 1 underflow expected, 2 overflow expected
  logic mon_on = 1'b0;
  logic prev_rd, in_frame, last_bit, seen_out;
  int   cnt, bad, cur_n, last_n, first_n, frames_done, repeats, skips;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic gen(int n, int p);
    int unsigned h;
    h = 32'(n) * 32'd2654435761 + 32'(p) * 32'd40503 + 32'd12345;
    h = h ^ (h >> 15);
    h = h * 32'd2246822519;
    h = h ^ (h >> 13);
    return h[20];
  endfunction

  function automatic bit cas_mark(int n); return (n % 4) == 1; endfunction
  function automatic bit crc_mark(int n); return (n % 4) == 2; endfunction

  // R8 layout: bit 0 framing one, then line timeslots skipping multiples of 4
  function automatic logic exp_bit(int n, int k, logic t1);
    int j, ts, lts;
    if (!t1) return gen(n, k);
    if (k == 0) return 1'b1;
    j   = k - 1;
    ts  = j / 8;
    lts = 4 * (ts / 3) + (ts % 3) + 1;
    return gen(n, lts * 8 + (j % 8));
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_rd) begin
        seen_out = 1'b1;
        if (slip_pulse && !rd_fsync)
          chk(0, "R6 slip pulse off frame boundary", 1, 0);
        if (rd_fsync) begin
          if (in_frame) chk(0, "R2 short frame", cnt, ph_t1 ? 193 : 256);
          if (slip_pulse && ph_kind == 0) chk(0, "R11 unexpected slip", 1, 0);
          if (slip_pulse && slip_under && ph_kind == 1) begin
            cur_n = last_n;  // R4 repeat
            repeats++;
          end else if (slip_pulse && slip_over && ph_kind == 2) begin
            if (exp_q.size() > 0) void'(exp_q.pop_front());  // R5 drop
            skips++;
            cur_n = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
          end else begin
            cur_n = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
          end
          if (first_n < 0) first_n = cur_n;
          chk(rd_msync == (ph_men && (ph_crc ? crc_mark(cur_n) : cas_mark(cur_n))),
              "R9 multiframe sync", int'(rd_msync), cur_n);
          in_frame = 1'b1;
          cnt = 0;
          bad = 0;
        end else if (!in_frame) begin
          chk(0, "R2 bit outside frame", 0, 1);
        end
        if (in_frame) begin
          if (rd_bit !== exp_bit(cur_n, cnt, ph_t1)) bad++;
          cnt++;
          if (cnt == (ph_t1 ? 193 : 256)) begin
            chk(bad == 0, ph_t1 ? "R8 193-bit frame content" : "R2 frame content", bad, 0);
            last_n = cur_n;
            frames_done++;
            in_frame = 1'b0;
          end
        end
      end else if (seen_out) begin
        if (rd_bit !== last_bit) chk(0, "R3 output changed without strobe", int'(rd_bit), int'(last_bit));
      end
      prev_rd  = rd_en;
      last_bit = rd_bit;
    end
  end

  task automatic idle_inputs();
    wr_en = 0; wr_bit = 0; wr_fsync = 0; wr_cas_mf = 0; wr_crc_mf = 0;
    rd_en = 0; recenter = 0; clr_status = 0;
  endtask

  task automatic run_phase(input int wr_num, input int wr_den, input int rd_num,
                           input int rd_den, input logic t1, input logic men,
                           input logic crc, input int kind, input int nframes);
    int wn, wp;
    mon_on = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;
    t1_mode = t1; msync_en = men; msync_crc = crc;
    ph_t1 = t1; ph_men = men; ph_crc = crc; ph_kind = kind;
    exp_q.delete();
    prev_rd = 0; in_frame = 0; seen_out = 0; last_bit = 0;
    cnt = 0; bad = 0; cur_n = -1; last_n = -1; first_n = -1;
    frames_done = 0; repeats = 0; skips = 0;
    repeat (4) @(posedge clk);
    #2;
    mon_on = 1;
    // misaligned junk, then frame 0 with sync (R10 realignment)
    for (int i = 0; i < 40; i++) begin
      wr_en = 1; wr_bit = 0; wr_fsync = 0;
      @(posedge clk); #2;
    end
    wn = 0; wp = 0;
    for (int c = 0; c < 256; c++) begin
      wr_en = 1; wr_bit = gen(wn, wp); wr_fsync = (wp == 0);
      wr_cas_mf = (wp == 0) && cas_mark(wn); wr_crc_mf = (wp == 0) && crc_mark(wn);
      if (wp == 0) exp_q.push_back(wn);
      wp++;
      @(posedge clk); #2;
    end
    wn = 1; wp = 0;
    idle_inputs();
    recenter = 1;  // R7
    @(posedge clk); #2;
    recenter = 0;
    for (int c = 0; c < 20000 && frames_done < nframes; c++) begin
      if ((c % wr_den) < wr_num && wn < nframes + 8) begin
        wr_en = 1; wr_bit = gen(wn, wp); wr_fsync = (wp == 0);
        wr_cas_mf = (wp == 0) && cas_mark(wn); wr_crc_mf = (wp == 0) && crc_mark(wn);
        if (wp == 0) exp_q.push_back(wn);
        wp++;
        if (wp == 256) begin wp = 0; wn++; end
      end else begin
        wr_en = 0; wr_fsync = 0; wr_cas_mf = 0; wr_crc_mf = 0;
      end
      rd_en = ((c % rd_den) < rd_num);
      @(posedge clk); #2;
    end
    idle_inputs();
    repeat (4) @(posedge clk);
    #2;
    chk(frames_done >= nframes, "R2 frames delivered", frames_done, nframes);
    chk(first_n == 0, "R7 R10 first frame after recenter", first_n, 0);
  endtask

  initial begin
    rst_n = 0;
    t1_mode = 0; msync_en = 0; msync_crc = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #2;
    chk({rd_bit, rd_fsync, rd_msync, slip_pulse, slip_under, slip_over} == 6'b0,
        "R1 outputs in reset", int'({rd_bit, rd_fsync, rd_msync, slip_pulse, slip_under, slip_over}), 0);
    rst_n = 1;
    repeat (5) @(posedge clk);
    #2;
    chk({rd_bit, rd_fsync, rd_msync, slip_pulse, slip_under, slip_over} == 6'b0,
        "R1 outputs after reset", int'({rd_bit, rd_fsync, rd_msync, slip_pulse, slip_under, slip_over}), 0);

    // equal rates, 2.048 layout, signalling multiframe tag
    run_phase(1, 2, 1, 2, 1'b0, 1'b1, 1'b0, 0, 6);
    chk(!slip_under && !slip_over, "R11 no slip at matched rates",
        int'({slip_under, slip_over}), 0);

    // reader faster: one repeated frame
    run_phase(7, 8, 8, 8, 1'b0, 1'b0, 1'b0, 1, 11);
    chk(repeats == 1, "R4 one frame repeated", repeats, 1);
    chk(slip_under && !slip_over, "R4 underflow flag", int'({slip_under, slip_over}), 2);
    repeat (20) @(posedge clk);
    #2;
    chk(slip_under, "R6 underflow flag sticky", int'(slip_under), 1);
    clr_status = 1;
    @(posedge clk); #2;
    clr_status = 0;
    chk(!slip_under && !slip_over, "R6 flags cleared", int'({slip_under, slip_over}), 0);

    // writer faster: one dropped frame, CRC multiframe tag
    run_phase(8, 8, 7, 8, 1'b0, 1'b1, 1'b1, 2, 10);
    chk(skips == 1, "R5 one frame dropped", skips, 1);
    chk(slip_over && !slip_under, "R5 overflow flag", int'({slip_under, slip_over}), 1);

    // 1.544 layout, close to matched frame rate
    run_phase(4, 4, 3, 4, 1'b1, 1'b1, 1'b1, 0, 6);
    chk(!slip_under && !slip_over, "R11 no slip in 193-bit mode",
        int'({slip_under, slip_over}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule